// File: doc/BRIEF.md
# Dual-Source Register Bank Arbiter

This block holds a small bank of status and interface registers. Each one can be loaded either by an on-chip producer or by an external host on a simple address/data/write-strobe bus. There are three register groups. The eight-entry interface group is normally written by the processing program. The single pin-setting register is normally refreshed from the sampled multipurpose pins. The four-entry auxiliary converter group is normally refreshed from the auxiliary converter path. Each producer delivers its update as a one-cycle strobe with an index and a data word.

A core control register holds one ownership bit per group. While a group's bit is clear, the internal producer owns the group and host writes to it are dropped. While the bit is set, the host owns the group and the producer's strobes are discarded. The host can read every register in the bank, and the control register, on a combinational read path at any time.

Top module: `regbank_owner_arb`

## Requirements
- R1: After reset the control register and every register in the three groups read 0, so every group starts owned by its internal producer.
- R2: The control register sits at address 2076. Bit 9 selects host ownership of the auxiliary group, bit 8 of the pin-setting register and bit 7 of the interface group. A host write changes ownership from the next clock edge. All other control bits read 0 and ignore writes.
- R3: While bit 7 is clear, a program strobe writes its data into interface register idx (address 2048+idx) at the next edge, and host writes to addresses 2048..2055 have no effect.
- R4: While bit 7 is set, host writes to addresses 2048..2055 land in the addressed interface register at the next edge, and program strobes have no effect.
- R5: While bit 8 is clear, a pin strobe loads the pin-setting register (address 2056), and host writes to 2056 have no effect.
- R6: While bit 8 is set, host writes load the pin-setting register, and pin strobes have no effect.
- R7: While bit 9 is clear, an auxiliary strobe writes auxiliary register idx (address 2057+idx), and host writes to 2057..2060 have no effect.
- R8: While bit 9 is set, host writes to 2057..2060 land in the addressed auxiliary register, and auxiliary strobes have no effect.
- R9: When a host write and an internal strobe target the same register in the same cycle, the source selected by the ownership bit wins and the other value is discarded.
- R10: Host reads return the current contents of the addressed register in the same cycle, whichever source wrote it last. Addresses outside the bank and the control register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 12 | Host read/write address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read data for host_addr |
| prog_we | input | 1 | Program write strobe to the interface group |
| prog_idx | input | 3 | Interface register index for the program write |
| prog_wdata | input | 16 | Program write data |
| pin_we | input | 1 | Pin-sample update strobe |
| pin_wdata | input | 16 | Sampled pin value |
| aux_we | input | 1 | Auxiliary converter update strobe |
| aux_idx | input | 2 | Auxiliary register index |
| aux_wdata | input | 16 | Auxiliary converter data |

## Verification
The hardest case to reach from the ports is the same-cycle collision. A host write and an internal strobe must hit the same register on one edge, and this must happen under each ownership setting. Only then can the bench show that the ownership bit decides the outcome rather than a fixed priority. The bench walks all eight combinations of the three ownership bits. Under each combination it drives, for every register in the bank, a lone host write, a lone internal strobe and a collision that carries two distinguishable values. It reads the register back after each cycle and compares it against a model derived from the ownership rules.

// File: rtl/rbo_pkg.sv
package rbo_pkg;

    localparam int DATA_W       = 16;
    localparam int ADDR_W       = 12;
    localparam int IF_BASE      = 2048;
    localparam int IF_NUM       = 8;
    localparam int PIN_ADDR     = 2056;
    localparam int AUX_BASE     = 2057;
    localparam int AUX_NUM      = 4;
    localparam int CTRL_ADDR    = 2076;

    // Ownership bit positions inside the control word
    localparam int MODE_AUX_BIT = 9;
    localparam int MODE_PIN_BIT = 8;
    localparam int MODE_IF_BIT  = 7;

    typedef struct packed {
        logic aux;
        logic pin;
        logic iface;
    } own_t;

endpackage

// File: rtl/rbo_host_decode.sv
module rbo_host_decode #(
    parameter int ADDR_W    = 12,
    parameter int IF_BASE   = 2048,
    parameter int IF_NUM    = 8,
    parameter int IF_IDX_W  = 3,
    parameter int PIN_ADDR  = 2056,
    parameter int AUX_BASE  = 2057,
    parameter int AUX_NUM   = 4,
    parameter int AUX_IDX_W = 2,
    parameter int CTRL_ADDR = 2076
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit_if,
    output logic [IF_IDX_W-1:0]  if_idx,
    output logic                 hit_pin,
    output logic                 hit_aux,
    output logic [AUX_IDX_W-1:0] aux_idx,
    output logic                 hit_ctrl
);

    int addr_i;
    int if_off;
    int aux_off;

    assign addr_i  = int'(addr);
    assign if_off  = addr_i - IF_BASE;
    assign aux_off = addr_i - AUX_BASE;

    always_comb begin
        hit_if   = (addr_i >= IF_BASE) && (addr_i < IF_BASE + IF_NUM);
        hit_pin  = (addr_i == PIN_ADDR);
        hit_aux  = (addr_i >= AUX_BASE) && (addr_i < AUX_BASE + AUX_NUM);
        hit_ctrl = (addr_i == CTRL_ADDR);
        if_idx   = hit_if  ? IF_IDX_W'(if_off)   : '0;
        aux_idx  = hit_aux ? AUX_IDX_W'(aux_off) : '0;
    end

endmodule

// File: rtl/rbo_ctrl_reg.sv
module rbo_ctrl_reg
    import rbo_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int AUX_BIT = 9,
    parameter int PIN_BIT = 8,
    parameter int IF_BIT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output own_t              own,
    output logic [DATA_W-1:0] ctrl_word
);

    own_t own_d, own_q;

    always_comb begin
        own_d = own_q;
        if (wr_en) begin
            own_d.aux   = wdata[AUX_BIT];
            own_d.pin   = wdata[PIN_BIT];
            own_d.iface = wdata[IF_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) own_q <= '0;
        else        own_q <= own_d;
    end

    // Only the ownership bits are stored; every other position reads 0
    always_comb begin
        ctrl_word          = '0;
        ctrl_word[AUX_BIT] = own_q.aux;
        ctrl_word[PIN_BIT] = own_q.pin;
        ctrl_word[IF_BIT]  = own_q.iface;
    end

    assign own = own_q;

endmodule

// File: rtl/rbo_reg_group.sv
module rbo_reg_group #(
    parameter int N      = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_own,
    input  logic                       host_we,
    input  logic [IDX_W-1:0]           host_idx,
    input  logic [DATA_W-1:0]          host_data,
    input  logic                       int_we,
    input  logic [IDX_W-1:0]           int_idx,
    input  logic [DATA_W-1:0]          int_data,
    output logic [N-1:0][DATA_W-1:0]   regs
);

    typedef struct packed {
        logic [N-1:0][DATA_W-1:0] regs;
    } grp_t;

    grp_t st_d, st_q;

    // The non-owning source is discarded outright, so a collision resolves
    // to whichever source the ownership bit selects.
    always_comb begin
        st_d = st_q;
        if (host_own) begin
            if (host_we && (int'(host_idx) < N))
                st_d.regs[host_idx] = host_data;
        end else begin
            if (int_we && (int'(int_idx) < N))
                st_d.regs[int_idx] = int_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs = st_q.regs;

endmodule

// File: rtl/regbank_owner_arb.sv
module regbank_owner_arb
    import rbo_pkg::*;
#(
    parameter int DATA_W    = rbo_pkg::DATA_W,
    parameter int ADDR_W    = rbo_pkg::ADDR_W,
    parameter int IF_BASE   = rbo_pkg::IF_BASE,
    parameter int IF_NUM    = rbo_pkg::IF_NUM,
    parameter int PIN_ADDR  = rbo_pkg::PIN_ADDR,
    parameter int AUX_BASE  = rbo_pkg::AUX_BASE,
    parameter int AUX_NUM   = rbo_pkg::AUX_NUM,
    parameter int CTRL_ADDR = rbo_pkg::CTRL_ADDR,
    localparam int IF_IDX_W  = (IF_NUM  > 1) ? $clog2(IF_NUM)  : 1,
    localparam int AUX_IDX_W = (AUX_NUM > 1) ? $clog2(AUX_NUM) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic                 host_we,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic [DATA_W-1:0]    host_rdata,
    input  logic                 prog_we,
    input  logic [IF_IDX_W-1:0]  prog_idx,
    input  logic [DATA_W-1:0]    prog_wdata,
    input  logic                 pin_we,
    input  logic [DATA_W-1:0]    pin_wdata,
    input  logic                 aux_we,
    input  logic [AUX_IDX_W-1:0] aux_idx,
    input  logic [DATA_W-1:0]    aux_wdata
);

    logic                          hit_if, hit_pin, hit_aux, hit_ctrl;
    logic [IF_IDX_W-1:0]           host_if_idx;
    logic [AUX_IDX_W-1:0]          host_aux_idx;
    own_t                          own;
    logic [DATA_W-1:0]             ctrl_word;
    logic [IF_NUM-1:0][DATA_W-1:0] if_regs;
    logic [0:0][DATA_W-1:0]        pin_regs;
    logic [AUX_NUM-1:0][DATA_W-1:0] aux_regs;

    rbo_host_decode #(
        .ADDR_W   (ADDR_W),
        .IF_BASE  (IF_BASE),
        .IF_NUM   (IF_NUM),
        .IF_IDX_W (IF_IDX_W),
        .PIN_ADDR (PIN_ADDR),
        .AUX_BASE (AUX_BASE),
        .AUX_NUM  (AUX_NUM),
        .AUX_IDX_W(AUX_IDX_W),
        .CTRL_ADDR(CTRL_ADDR)
    ) dec_i (
        .addr    (host_addr),
        .hit_if  (hit_if),
        .if_idx  (host_if_idx),
        .hit_pin (hit_pin),
        .hit_aux (hit_aux),
        .aux_idx (host_aux_idx),
        .hit_ctrl(hit_ctrl)
    );

    rbo_ctrl_reg #(
        .DATA_W (DATA_W),
        .AUX_BIT(MODE_AUX_BIT),
        .PIN_BIT(MODE_PIN_BIT),
        .IF_BIT (MODE_IF_BIT)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_we && hit_ctrl),
        .wdata    (host_wdata),
        .own      (own),
        .ctrl_word(ctrl_word)
    );

    rbo_reg_group #(.N(IF_NUM), .DATA_W(DATA_W), .IDX_W(IF_IDX_W)) if_grp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_own (own.iface),
        .host_we  (host_we && hit_if),
        .host_idx (host_if_idx),
        .host_data(host_wdata),
        .int_we   (prog_we),
        .int_idx  (prog_idx),
        .int_data (prog_wdata),
        .regs     (if_regs)
    );

    rbo_reg_group #(.N(1), .DATA_W(DATA_W), .IDX_W(1)) pin_grp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_own (own.pin),
        .host_we  (host_we && hit_pin),
        .host_idx (1'b0),
        .host_data(host_wdata),
        .int_we   (pin_we),
        .int_idx  (1'b0),
        .int_data (pin_wdata),
        .regs     (pin_regs)
    );

    rbo_reg_group #(.N(AUX_NUM), .DATA_W(DATA_W), .IDX_W(AUX_IDX_W)) aux_grp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_own (own.aux),
        .host_we  (host_we && hit_aux),
        .host_idx (host_aux_idx),
        .host_data(host_wdata),
        .int_we   (aux_we),
        .int_idx  (aux_idx),
        .int_data (aux_wdata),
        .regs     (aux_regs)
    );

    always_comb begin
        host_rdata = '0;
        if (hit_if)        host_rdata = if_regs[host_if_idx];
        else if (hit_pin)  host_rdata = pin_regs[0];
        else if (hit_aux)  host_rdata = aux_regs[host_aux_idx];
        else if (hit_ctrl) host_rdata = ctrl_word;
    end

endmodule

// File: rtl/rbo_checker.sv
module rbo_checker #(
    parameter int DATA_W  = 16,
    parameter int IF_NUM  = 8,
    parameter int AUX_NUM = 4,
    parameter logic [DATA_W-1:0] MODE_MASK = 16'h0380
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           host_we,
    input logic [DATA_W-1:0]              host_rdata,
    input logic                           prog_we,
    input logic                           pin_we,
    input logic                           aux_we,
    input logic                           hit_if,
    input logic                           hit_pin,
    input logic                           hit_aux,
    input logic                           hit_ctrl,
    input logic                           own_if,
    input logic                           own_pin,
    input logic                           own_aux,
    input logic [IF_NUM-1:0][DATA_W-1:0]  if_regs,
    input logic [DATA_W-1:0]              pin_val,
    input logic [AUX_NUM-1:0][DATA_W-1:0] aux_regs
);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ctrl |-> ((host_rdata & ~MODE_MASK) == '0));

    a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && hit_ctrl) |=> $stable({own_aux, own_pin, own_if}));

    a_r3_if_host_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_if && !prog_we) |=> $stable(if_regs));

    a_r4_if_prog_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (own_if && !(host_we && hit_if)) |=> $stable(if_regs));

    a_r5_pin_host_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_pin && !pin_we) |=> $stable(pin_val));

    a_r6_pin_samp_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (own_pin && !(host_we && hit_pin)) |=> $stable(pin_val));

    a_r7_aux_host_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_aux && !aux_we) |=> $stable(aux_regs));

    a_r8_aux_conv_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (own_aux && !(host_we && hit_aux)) |=> $stable(aux_regs));

    a_r10_pin_readback: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pin |-> (host_rdata == pin_val));

endmodule

bind regbank_owner_arb rbo_checker #(
    .DATA_W (DATA_W),
    .IF_NUM (IF_NUM),
    .AUX_NUM(AUX_NUM)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (host_we),
    .host_rdata(host_rdata),
    .prog_we   (prog_we),
    .pin_we    (pin_we),
    .aux_we    (aux_we),
    .hit_if    (hit_if),
    .hit_pin   (hit_pin),
    .hit_aux   (hit_aux),
    .hit_ctrl  (hit_ctrl),
    .own_if    (own.iface),
    .own_pin   (own.pin),
    .own_aux   (own.aux),
    .if_regs   (if_regs),
    .pin_val   (pin_regs[0]),
    .aux_regs  (aux_regs)
);

// File: tb/regbank_owner_arb_tb_top.sv
module regbank_owner_arb_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] host_addr = '0;
    logic        host_we = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        prog_we = 1'b0;
    logic [2:0]  prog_idx = '0;
    logic [15:0] prog_wdata = '0;
    logic        pin_we = 1'b0;
    logic [15:0] pin_wdata = '0;
    logic        aux_we = 1'b0;
    logic [1:0]  aux_idx = '0;
    logic [15:0] aux_wdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] exp_if [8];
    logic [15:0] exp_pin;
    logic [15:0] exp_aux [4];
    logic [15:0] exp_ctrl;

    always #2 clk = ~clk;

    regbank_owner_arb dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .prog_we(prog_we), .prog_idx(prog_idx), .prog_wdata(prog_wdata),
        .pin_we(pin_we), .pin_wdata(pin_wdata),
        .aux_we(aux_we), .aux_idx(aux_idx), .aux_wdata(aux_wdata)
    );

    task automatic check_rd(input int addr, input logic [15:0] exp, input string tag);
        host_addr = 12'(addr);
        #1;
        checks++;
        if (host_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, addr, host_rdata, exp);
        end
    endtask

    // One clock of stimulus; the model follows the ownership rules
    task automatic do_cycle(input bit hw, input int ha, input logic [15:0] hd,
                            input bit pw, input int pi, input logic [15:0] pd,
                            input bit nw, input logic [15:0] nd,
                            input bit aw, input int ai, input logic [15:0] ad);
        logic [15:0] own;
        @(negedge clk);
        host_we = hw; host_addr = 12'(ha); host_wdata = hd;
        prog_we = pw; prog_idx = 3'(pi); prog_wdata = pd;
        pin_we = nw; pin_wdata = nd;
        aux_we = aw; aux_idx = 2'(ai); aux_wdata = ad;
        own = exp_ctrl;
        if (own[7]) begin
            if (hw && ha >= 2048 && ha < 2056) exp_if[ha-2048] = hd;
        end else if (pw) exp_if[pi] = pd;
        if (own[8]) begin
            if (hw && ha == 2056) exp_pin = hd;
        end else if (nw) exp_pin = nd;
        if (own[9]) begin
            if (hw && ha >= 2057 && ha < 2061) exp_aux[ha-2057] = hd;
        end else if (aw) exp_aux[ai] = ad;
        if (hw && ha == 2076) exp_ctrl = hd & 16'h0380;
        @(negedge clk);
        host_we = 1'b0; prog_we = 1'b0; pin_we = 1'b0; aux_we = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) exp_if[i] = '0;
        for (int i = 0; i < 4; i++) exp_aux[i] = '0;
        exp_pin = '0;
        exp_ctrl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every register
        for (int a = 2048; a <= 2060; a++) check_rd(a, 16'h0000, "R1");
        check_rd(2076, 16'h0000, "R1");

        // R10: unmapped addresses read 0
        check_rd(2047, 16'h0000, "R10");
        check_rd(2061, 16'h0000, "R10");
        check_rd(2075, 16'h0000, "R10");

        for (int m = 0; m < 8; m++) begin
            // R2: reserved bits ignore writes, ownership bits stick
            do_cycle(1, 2076, 16'hFC7F | 16'(m << 7), 0, 0, 0, 0, 0, 0, 0, 0);
            check_rd(2076, 16'(m << 7), "R2");

            for (int i = 0; i < 8; i++) begin
                do_cycle(1, 2048 + i, 16'hA000 | 16'(m << 4) | 16'(i), 0, 0, 0, 0, 0, 0, 0, 0);
                check_rd(2048 + i, exp_if[i], (m & 1) ? "R4" : "R3");
                do_cycle(0, 0, 0, 1, i, 16'h5000 | 16'(m << 4) | 16'(i), 0, 0, 0, 0, 0);
                check_rd(2048 + i, exp_if[i], (m & 1) ? "R4" : "R3");
                do_cycle(1, 2048 + i, 16'h1100 | 16'(m << 4) | 16'(i), 1, i, 16'h2200 | 16'(m << 4) | 16'(i), 0, 0, 0, 0, 0);
                check_rd(2048 + i, exp_if[i], "R9");
            end

            do_cycle(1, 2056, 16'hB000 | 16'(m), 0, 0, 0, 0, 0, 0, 0, 0);
            check_rd(2056, exp_pin, (m & 2) ? "R6" : "R5");
            do_cycle(0, 0, 0, 0, 0, 0, 1, 16'h3000 | 16'(m), 0, 0, 0);
            check_rd(2056, exp_pin, (m & 2) ? "R6" : "R5");
            do_cycle(1, 2056, 16'h3300 | 16'(m), 0, 0, 0, 1, 16'h4400 | 16'(m), 0, 0, 0);
            check_rd(2056, exp_pin, "R9");

            for (int i = 0; i < 4; i++) begin
                do_cycle(1, 2057 + i, 16'hC000 | 16'(m << 4) | 16'(i), 0, 0, 0, 0, 0, 0, 0, 0);
                check_rd(2057 + i, exp_aux[i], (m & 4) ? "R8" : "R7");
                do_cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, i, 16'h6000 | 16'(m << 4) | 16'(i));
                check_rd(2057 + i, exp_aux[i], (m & 4) ? "R8" : "R7");
                do_cycle(1, 2057 + i, 16'h5500 | 16'(m << 4) | 16'(i), 0, 0, 0, 0, 0, 1, i, 16'h6600 | 16'(m << 4) | 16'(i));
                check_rd(2057 + i, exp_aux[i], "R9");
            end

            // R10: all contents still read back after the sweep for this mode
            for (int i = 0; i < 8; i++) check_rd(2048 + i, exp_if[i], "R10");
            check_rd(2056, exp_pin, "R10");
            for (int i = 0; i < 4; i++) check_rd(2057 + i, exp_aux[i], "R10");
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule